// File: doc/BRIEF.md
# Adaptive Bit-Tree Symbol Decoder

This block pulls a multi-bit symbol out of a range-coded byte stream, one adaptive binary decision at a time. Each decision reads an 11-bit probability from a local table. The table entry is chosen by the bits already decoded. The decision then updates that entry, so the table learns the statistics of the stream. The range-coder arithmetic is built in: renormalisation, bound computation and the range/code update. The block also has a byte-wide input port with a valid/ready handshake.

Three tree shapes are selected by a start strobe:
- A forward tree of 1 to 8 levels, MSB first, with a constant added at the end.
- A fixed 4-level reverse tree, LSB first.
- A variable-length reverse tree that adds a caller-supplied weight, scaled by bit position, into an accumulator.

The caller pulses `start` with the command fields, waits for `done`, and reads `result`. Out of reset the block first loads its 32-bit code register from the stream.

Top module: `bittree_decoder`

## Requirements
- R1: After reset, `busy` is high while the block takes exactly five bytes from the stream. The first byte is shifted out of the code register and the last four form it big-endian. `busy` then falls. Range starts at 0xFFFFFFFF and every table entry starts at 1024.
- R2: Mode 0 (and mode 3) is the forward tree. The symbol starts at 1. Each step decides with entry[symbol] and sets symbol = 2*symbol + bit for `depth` steps. `result` = symbol + `final_add` modulo 2^16. A `depth` of 0 or above 8 means 8.
- R3: Mode 1 is the reverse 4-level tree. The symbol starts at 0. Step k (0..3) decides with entry[symbol + 2^k] and adds 2^k when the bit is 1. `result` is that symbol (0..15), and `depth` and `final_add` have no effect.
- R4: Mode 2 is the variable reverse tree. The symbol starts at 1, each step uses entry[symbol] and sets symbol = 2*symbol + bit, for `depth` steps. `result` = `final_add` plus `weight`<<k for every step k whose bit is 1, modulo 2^16.
- R5: For each decision, bound = (range>>11)*p. The bit is 1 when code >= bound. A 0 sets range = bound and p += (2048-p)>>5. A 1 subtracts bound from range and from code and sets p -= p>>5. The new p is written back to the entry used.
- R6: Before any decision taken with range below 2^24, one byte is consumed. Range is shifted left 8, and code is shifted left 8 with the byte in its low bits. This costs one cycle.
- R7: While a byte is needed and `in_valid` is low, the decode holds its state, and the result is the same as without the stall.
- R8: `clr_tbl` while idle resets every table entry to 1024 on the next edge.
- R9: With `in_valid` held high, `done` pulses for one cycle exactly depth+n cycles after the edge that takes `start`, where n is the number of bytes consumed. At that point `busy` is already low, and `result` holds its value until the next completion.
- R10: `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_tbl | input | 1 | Reset probability table (honoured when idle) |
| start | input | 1 | Begin a symbol decode (honoured when idle) |
| mode | input | 2 | 0/3 forward, 1 reverse-4, 2 variable reverse |
| depth | input | 4 | Step count for modes 0 and 2 (0 or >8 means 8) |
| final_add | input | 16 | Constant added to the forward result, or accumulator start value |
| weight | input | 16 | Weight of step 0 in variable reverse mode |
| in_valid | input | 1 | Input byte present |
| in_byte | input | 8 | Input byte |
| in_ready | output | 1 | Block consumes `in_byte` at this edge when `in_valid` is high |
| busy | output | 1 | Loading the code register or decoding |
| done | output | 1 | One-cycle pulse: `result` updated |
| result | output | 16 | Decoded symbol or accumulator value |

## Verification
Each decoded bit costs one cycle, and each consumed byte costs one more. So with the stream never stalled, `done` is due depth+n cycles after the start edge, where n is the number of bytes consumed. The bench's model counts n while it predicts the result, and the bench compares the cycle on which `done` appears against that count. With random stalls on `in_valid`, the check drops the cycle count and keeps the result comparison. Outputs are sampled at the falling edge, where the registered `done` and `result` are settled.

// File: rtl/bittree_decoder.sv
module bittree_decoder #(
  parameter int PROB_BITS  = 11,
  parameter int MOVE_BITS  = 5,
  parameter int MAX_LEVELS = 8,
  parameter int OUT_W      = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               clr_tbl,
  input  logic                               start,
  input  logic [1:0]                         mode,
  input  logic [$clog2(MAX_LEVELS+1)-1:0]    depth,
  input  logic [OUT_W-1:0]                   final_add,
  input  logic [OUT_W-1:0]                   weight,
  input  logic                               in_valid,
  input  logic [7:0]                         in_byte,
  output logic                               in_ready,
  output logic                               busy,
  output logic                               done,
  output logic [OUT_W-1:0]                   result
);
  localparam int TBL     = 1 << MAX_LEVELS;
  localparam int IDX_W   = MAX_LEVELS;
  localparam int SYM_W   = MAX_LEVELS + 1;
  localparam int STEP_W  = $clog2(MAX_LEVELS);
  localparam int DEPTH_W = $clog2(MAX_LEVELS + 1);
  localparam logic [PROB_BITS-1:0] P_INIT = PROB_BITS'(1 << (PROB_BITS - 1));
  localparam logic [PROB_BITS:0]   P_ONE  = (PROB_BITS + 1)'(1) << PROB_BITS;
  localparam logic [31:0]          TOP    = 32'h0100_0000;
  localparam logic [1:0] M_REV4 = 2'd1, M_VREV = 2'd2;

  typedef enum logic [1:0] {S_INIT, S_IDLE, S_BIT} state_t;

  state_t                 state;
  logic [31:0]            range, code;
  logic [2:0]             init_cnt;
  logic [1:0]             mode_r;
  logic [DEPTH_W-1:0]     depth_r;
  logic [OUT_W-1:0]       fadd_r, wt_r, acc;
  logic [SYM_W-1:0]       sym;
  logic [STEP_W-1:0]      step;
  logic [PROB_BITS-1:0]   probs [TBL];

  logic                   need_byte, bit_one, last;
  logic [IDX_W-1:0]       rev_bit, idx;
  logic [PROB_BITS-1:0]   p_cur, p_next;
  logic [PROB_BITS:0]     up_gap;
  logic [31:0]            bound;
  logic [SYM_W-1:0]       sym_next;
  logic [OUT_W-1:0]       acc_next, res_next;
  logic [DEPTH_W-1:0]     depth_in;

  assign need_byte = range < TOP;
  assign in_ready  = (state == S_INIT) || (state == S_BIT && need_byte);
  assign busy      = state != S_IDLE;

  assign rev_bit = IDX_W'(1) << step;
  assign idx     = (mode_r == M_REV4) ? sym[IDX_W-1:0] + rev_bit : sym[IDX_W-1:0];
  assign p_cur   = probs[idx];
  assign bound   = (range >> PROB_BITS) * {{(32-PROB_BITS){1'b0}}, p_cur};
  assign bit_one = code >= bound;
  assign up_gap  = P_ONE - {1'b0, p_cur};
  assign p_next  = bit_one ? p_cur - (p_cur >> MOVE_BITS)
                           : p_cur + PROB_BITS'(up_gap >> MOVE_BITS);

  assign sym_next = (mode_r == M_REV4)
                  ? (sym | {{(SYM_W-IDX_W){1'b0}}, (bit_one ? rev_bit : IDX_W'(0))})
                  : {sym[SYM_W-2:0], bit_one};
  assign acc_next = acc + (bit_one ? wt_r : OUT_W'(0));
  assign last     = DEPTH_W'(step) == depth_r - DEPTH_W'(1);
  assign depth_in = (depth == 0 || int'(depth) > MAX_LEVELS) ? DEPTH_W'(MAX_LEVELS) : depth;

  always_comb begin
    case (mode_r)
      M_REV4:  res_next = OUT_W'(sym_next);
      M_VREV:  res_next = acc_next;
      default: res_next = OUT_W'(sym_next) + fadd_r;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_INIT;
      range    <= 32'hFFFF_FFFF;
      code     <= '0;
      init_cnt <= '0;
      mode_r   <= '0;
      depth_r  <= '0;
      fadd_r   <= '0;
      wt_r     <= '0;
      acc      <= '0;
      sym      <= '0;
      step     <= '0;
      done     <= 1'b0;
      result   <= '0;
      for (int i = 0; i < TBL; i++) probs[i] <= P_INIT;
    end else begin
      done <= 1'b0;
      case (state)
        S_INIT: if (in_valid) begin
          code     <= {code[23:0], in_byte};
          init_cnt <= init_cnt + 3'd1;
          if (init_cnt == 3'd4) state <= S_IDLE;
        end
        S_IDLE: begin
          if (clr_tbl)
            for (int i = 0; i < TBL; i++) probs[i] <= P_INIT;
          if (start) begin
            mode_r  <= mode;
            depth_r <= (mode == M_REV4) ? DEPTH_W'(4) : depth_in;
            fadd_r  <= final_add;
            wt_r    <= weight;
            acc     <= final_add;
            sym     <= (mode == M_REV4) ? SYM_W'(0) : SYM_W'(1);
            step    <= '0;
            state   <= S_BIT;
          end
        end
        S_BIT: begin
          if (need_byte) begin
            if (in_valid) begin
              range <= range << 8;
              code  <= {code[23:0], in_byte};
            end
          end else begin
            probs[idx] <= p_next;
            range      <= bit_one ? range - bound : bound;
            code       <= bit_one ? code - bound : code;
            sym        <= sym_next;
            acc        <= acc_next;
            wt_r       <= wt_r << 1;
            step       <= step + STEP_W'(1);
            if (last) begin
              result <= res_next;
              done   <= 1'b1;
              state  <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(state) == S_BIT);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BIT && need_byte && !in_valid)
      |=> $stable(code) && $stable(range) && $stable(sym) && $stable(step));

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mode_r) && $stable(depth_r) && $stable(fadd_r));

  // R6
  range_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    range != 32'd0);

  // R5
  prob_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BIT) |-> (p_cur != '0) && ({1'b0, p_cur} < P_ONE));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_tbl && state == S_IDLE) |=> probs[1] == P_INIT);
endmodule

// File: tb/bittree_decoder_tb.sv
module bittree_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_tbl = 1'b0, start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [3:0]  depth = 4'd0;
  logic [15:0] final_add = 16'd0, weight = 16'd0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'd0;
  logic        in_ready, busy, done;
  logic [15:0] result;

  bittree_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .clr_tbl(clr_tbl), .start(start), .mode(mode),
    .depth(depth), .final_add(final_add), .weight(weight), .in_valid(in_valid),
    .in_byte(in_byte), .in_ready(in_ready), .busy(busy), .done(done), .result(result)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int ptr = 0, stall_pct = 0;
  bit hs_prev = 1'b0;

  function automatic logic [7:0] fbyte(int n);
    if (n == 0) return 8'h00;
    if (n == 1) return 8'h5A;
    return 8'((n * 151) ^ ((n >> 3) * 29) ^ (n >> 9) + 7);
  endfunction

  always @(negedge clk) begin
    if (hs_prev) ptr++;
    in_valid = ($urandom % 100) >= stall_pct;
    in_byte  = fbyte(ptr);
    hs_prev  = in_valid && in_ready && rst_n;
  end

  // reference model
  logic [31:0] m_range, m_code;
  int m_ptr, m_norms;
  int m_probs [256];

  function automatic void m_clear();
    for (int i = 0; i < 256; i++) m_probs[i] = 1024;
  endfunction

  function automatic int m_bit(int idx);
    logic [31:0] bnd;
    int b;
    if (m_range < 32'h0100_0000) begin
      m_range = m_range << 8;
      m_code  = (m_code << 8) | {24'd0, fbyte(m_ptr)};
      m_ptr++;
      m_norms++;
    end
    bnd = (m_range >> 11) * 32'(m_probs[idx]);
    b = (m_code >= bnd) ? 1 : 0;
    if (b == 1) begin
      m_range = m_range - bnd;
      m_code  = m_code - bnd;
      m_probs[idx] = m_probs[idx] - (m_probs[idx] >> 5);
    end else begin
      m_range = bnd;
      m_probs[idx] = m_probs[idx] + ((2048 - m_probs[idx]) >> 5);
    end
    return b;
  endfunction

  function automatic logic [15:0] m_decode(int md, int d, logic [15:0] fa, logic [15:0] wt);
    int s, b;
    logic [15:0] acc;
    m_norms = 0;
    if (d == 0 || d > 8) d = 8;
    if (md == 1) begin
      s = 0;
      for (int k = 0; k < 4; k++) begin
        b = m_bit(s + (1 << k));
        s = s + (b << k);
      end
      return 16'(s);
    end else if (md == 2) begin
      s = 1; acc = fa;
      for (int k = 0; k < d; k++) begin
        b = m_bit(s);
        s = 2 * s + b;
        if (b == 1) acc = acc + (wt << k);
      end
      return acc;
    end
    s = 1;
    for (int k = 0; k < d; k++) begin
      b = m_bit(s);
      s = 2 * s + b;
    end
    return 16'(s) + fa;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_sym(int md, int d, logic [15:0] fa, logic [15:0] wt, bit lat, string req);
    logic [15:0] exp;
    int c, dd;
    exp = m_decode(md, d, fa, wt);
    dd = (md == 1) ? 4 : ((d == 0 || d > 8) ? 8 : d);
    @(negedge clk);
    start = 1'b1; mode = 2'(md); depth = 4'(d); final_add = fa; weight = wt;
    @(negedge clk);
    start = 1'b0;
    c = 1;
    while (!done && c < 3000) begin
      @(negedge clk);
      c++;
    end
    check(done && result == exp, req, int'(result), int'(exp));
    if (lat) check(c == dd + m_norms + 1, "R9 latency", c, dd + m_norms + 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp_a;
    void'($urandom(32'd2718));
    m_clear();
    m_range = 32'hFFFF_FFFF;
    m_code = 32'd0;
    for (int i = 0; i < 5; i++) m_code = (m_code << 8) | {24'd0, fbyte(i)};
    m_ptr = 5;

    stall_pct = 30;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b1 && done == 1'b0, "R1 busy at reset", int'(busy), 1);
    @(posedge clk); #1 rst_n = 1'b1;
    begin
      int w = 0;
      while (busy && w < 200) begin @(negedge clk); w++; end
    end
    @(negedge clk);
    check(ptr == 5, "R1 init byte count", ptr, 5);
    check(busy == 1'b0, "R1 idle after init", int'(busy), 0);

    // directed, no stalls, latency checked
    stall_pct = 0;
    run_sym(0, 3, 16'hFFF8, 16'd0, 1, "R2 depth3 strip leading one");
    run_sym(0, 6, 16'd2, 16'd0, 1, "R2 depth6 offset");
    run_sym(0, 8, 16'hFF00, 16'd0, 1, "R2 depth8");
    run_sym(1, 7, 16'h1234, 16'd0, 1, "R3 reverse4 ignores depth and final_add");
    run_sym(2, 5, 16'h0040, 16'd1, 1, "R4 variable reverse");
    run_sym(2, 8, 16'd0, 16'd3, 1, "R4 R5 variable reverse weight 3");
    run_sym(0, 0, 16'd0, 16'd0, 1, "R2 depth0 as 8");
    for (int i = 0; i < 20; i++) run_sym(0, 1, 16'd0, 16'd0, 1, "R5 R6 repeated single entry");

    // R10: start while busy is ignored
    exp_a = m_decode(0, 8, 16'd0, 16'd0);
    @(negedge clk);
    start = 1'b1; mode = 2'd0; depth = 4'd8; final_add = 16'd0;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    start = 1'b1; mode = 2'd1; final_add = 16'h7777;
    @(negedge clk); start = 1'b0;
    begin
      int w = 0;
      while (!done && w < 500) begin @(negedge clk); w++; end
    end
    check(result == exp_a, "R10 start while busy", int'(result), int'(exp_a));
    @(negedge clk); @(negedge clk);
    check(busy == 1'b0, "R10 no second decode", int'(busy), 0);

    // R8 table clear
    @(negedge clk); clr_tbl = 1'b1;
    @(negedge clk); clr_tbl = 1'b0;
    m_clear();
    check(busy == 1'b0, "R8 clear keeps idle", int'(busy), 0);
    run_sym(0, 8, 16'd0, 16'd0, 1, "R8 decode after clear");
    run_sym(1, 4, 16'd0, 16'd0, 1, "R8 R3 reverse after clear");

    // R7 heavy stalls
    stall_pct = 85;
    for (int i = 0; i < 10; i++) run_sym(i % 3, 8, 16'd5, 16'd2, 0, "R7 stalled decode");

    // random mix
    for (int i = 0; i < 150; i++) begin
      int md, d;
      stall_pct = ($urandom % 2 == 0) ? 0 : 40;
      md = int'($urandom % 4);
      d = 1 + int'($urandom % 8);
      if (i % 37 == 36) begin
        @(negedge clk); clr_tbl = 1'b1;
        @(negedge clk); clr_tbl = 1'b0;
        m_clear();
      end
      run_sym(md, d, 16'($urandom), 16'($urandom % 64), stall_pct == 0,
              "R2 R3 R4 R5 R6 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule